// File: doc/BRIEF.md
# Isochronous Split Microframe Scheduler

This block schedules the split transactions of a single isochronous descriptor across the eight microframes of a bus frame. Software loads four things at once: a start-split mask, a complete-split mask, a transfer direction and a 5-bit target frame number. After that, each microframe tick supplies the current frame number and the current microframe index. If the frame numbers agree, the block issues at most one request for that microframe, either a start split or a complete split, and tags it with the slot index.

A transaction engine reports the outcome of each request over a result interface. The result carries a slot index, a 3-bit status and a byte count. The scheduler keeps the status and the byte count for each slot, and it clears the active bit of the slot that was just served. A done flag goes high once no start-split or complete-split bit is left. Software reads the stored result of any slot through a combinational read port.

Top module: `iso_split_sched`

## Requirements
- R1: A load pulse takes in the masks, the direction (1 = IN) and the frame number. It clears all stored status fields and byte counts to zero, and it clears the error flag. When a load and a result arrive in the same cycle, the load wins and the result is dropped.
- R2: Active bits are set only by a load. A result for slot s clears start-split bit s if that bit is 1. Otherwise it clears complete-split bit s if that bit is 1. No other event clears an active bit.
- R3: On a tick whose current frame differs from the loaded frame number, no request is issued.
- R4: An IN load that has any start-split bit from 4 to 7 set is rejected. Both masks become zero and the error flag rises. It stays high until the next accepted load.
- R5: The complete-split mask is used only for IN. An OUT load stores a complete-split mask of zero.
- R6: On a tick with matching frame and microframe u, the block raises req_valid_o in the next cycle, for one cycle, with req_slot_o = u. If start bit u is set, req_is_cs_o = 0. Otherwise, if complete bit u is set, req_is_cs_o = 1. If neither bit is set, there is no request. Without a tick, req_valid_o stays low.
- R7: The stored status keeps bit 0 (transaction error) for both directions. It keeps bit 1 (babble) only for IN and bit 2 (underrun) only for OUT. The bit that does not apply to the direction is stored as 0.
- R8: A result is stored only when its slot has an active start or complete bit. A result for an inactive slot leaves that slot's status, byte count and active bits unchanged.
- R9: done_o is 1 exactly when both masks are all zero.
- R10: rd_status_o and rd_bytes_o show the stored values of slot rd_slot_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Descriptor load strobe |
| load_ss_mask_i | input | 8 | Start-split microframe mask |
| load_cs_mask_i | input | 8 | Complete-split microframe mask |
| load_is_in_i | input | 1 | Direction, 1 = IN, 0 = OUT |
| load_frame_i | input | 5 | Target frame number |
| tick_i | input | 1 | Microframe tick |
| cur_frame_i | input | 5 | Current bus frame number |
| cur_uframe_i | input | 3 | Current microframe index |
| req_valid_o | output | 1 | Request strobe |
| req_is_cs_o | output | 1 | 1 = complete split, 0 = start split |
| req_slot_o | output | 3 | Slot index of the request |
| res_valid_i | input | 1 | Result strobe |
| res_slot_i | input | 3 | Slot index of the result |
| res_status_i | input | 3 | Raw status: bit0 error, bit1 babble, bit2 underrun |
| res_bytes_i | input | 8 | Byte count of the result |
| rd_slot_i | input | 3 | Read-port slot select |
| rd_status_o | output | 3 | Stored status of the selected slot |
| rd_bytes_o | output | 8 | Stored byte count of the selected slot |
| ss_active_o | output | 8 | Live start-split mask |
| cs_active_o | output | 8 | Live complete-split mask |
| load_err_o | output | 1 | Rejected-load flag |
| done_o | output | 1 | No active bits left |

## Verification
The bench builds the block with its default parameters: eight slots, 5-bit frame numbers, 8-bit byte counts and a start-split limit of four for IN. These values reach every slot of the 0x01/0x04 schedule. They also let the bench reach the IN rejection boundary between slots 3 and 4, and both direction-dependent status bits. Random descriptors and random frame-match choices exercise the cases where start and complete bits overlap in one slot, where results arrive for idle slots, and where several loads are issued in turn.

// File: rtl/iso_split_pkg.sv
package iso_split_pkg;
  localparam int unsigned STAT_W = 3;
  localparam int unsigned ST_ERR = 0;
  localparam int unsigned ST_BABBLE = 1;
  localparam int unsigned ST_UNDERRUN = 2;

  typedef enum logic {
    REQ_START    = 1'b0,
    REQ_COMPLETE = 1'b1
  } req_kind_e;

  function automatic logic [STAT_W-1:0] status_keep(input logic is_in);
    logic [STAT_W-1:0] m;
    m = '0;
    m[ST_ERR] = 1'b1;
    m[ST_BABBLE] = is_in;
    m[ST_UNDERRUN] = ~is_in;
    return m;
  endfunction
endpackage

// File: rtl/iso_split_pick.sv
module iso_split_pick #(
  parameter int unsigned NUM_UF = 8,
  parameter int unsigned SLOT_W = $clog2(NUM_UF)
) (
  input  logic [NUM_UF-1:0] ss_act_i,
  input  logic [NUM_UF-1:0] cs_act_i,
  input  logic              frame_hit_i,
  input  logic [SLOT_W-1:0] uframe_i,
  output logic              hit_o,
  output iso_split_pkg::req_kind_e kind_o
);
  import iso_split_pkg::*;

  logic ss_bit;
  logic cs_bit;

  always_comb begin
    ss_bit = ss_act_i[uframe_i];
    cs_bit = cs_act_i[uframe_i];
    hit_o  = frame_hit_i & (ss_bit | cs_bit);
    kind_o = ss_bit ? REQ_START : REQ_COMPLETE;
  end
endmodule

// File: rtl/iso_slot_store.sv
module iso_slot_store #(
  parameter int unsigned NUM_UF = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned SLOT_W = $clog2(NUM_UF)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clr_all_i,
  input  logic                               wr_en_i,
  input  logic [SLOT_W-1:0]                  wr_slot_i,
  input  logic [iso_split_pkg::STAT_W-1:0]   wr_stat_i,
  input  logic [CNT_W-1:0]                   wr_bytes_i,
  input  logic [SLOT_W-1:0]                  rd_slot_i,
  output logic [iso_split_pkg::STAT_W-1:0]   rd_stat_o,
  output logic [CNT_W-1:0]                   rd_bytes_o
);
  import iso_split_pkg::*;

  logic [STAT_W-1:0] stat_q [NUM_UF];
  logic [CNT_W-1:0]  bytes_q [NUM_UF];

  for (genvar g = 0; g < NUM_UF; g++) begin : g_slot
    logic              en;
    logic [STAT_W-1:0] stat_d;
    logic [CNT_W-1:0]  bytes_d;

    always_comb begin
      en      = clr_all_i | (wr_en_i & (wr_slot_i == SLOT_W'(g)));
      stat_d  = clr_all_i ? '0 : wr_stat_i;
      bytes_d = clr_all_i ? '0 : wr_bytes_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[g]  <= '0;
        bytes_q[g] <= '0;
      end else if (en) begin
        stat_q[g]  <= stat_d;
        bytes_q[g] <= bytes_d;
      end
    end
  end

  always_comb begin
    rd_stat_o  = stat_q[rd_slot_i];
    rd_bytes_o = bytes_q[rd_slot_i];
  end
endmodule

// File: rtl/iso_split_sched.sv
module iso_split_sched #(
  parameter int unsigned NUM_UF      = 8,
  parameter int unsigned FRM_W       = 5,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned IN_SS_LIMIT = 4,
  localparam int unsigned SLOT_W     = $clog2(NUM_UF),
  localparam int unsigned STAT_W     = iso_split_pkg::STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [NUM_UF-1:0] load_ss_mask_i,
  input  logic [NUM_UF-1:0] load_cs_mask_i,
  input  logic              load_is_in_i,
  input  logic [FRM_W-1:0]  load_frame_i,
  input  logic              tick_i,
  input  logic [FRM_W-1:0]  cur_frame_i,
  input  logic [SLOT_W-1:0] cur_uframe_i,
  output logic              req_valid_o,
  output logic              req_is_cs_o,
  output logic [SLOT_W-1:0] req_slot_o,
  input  logic              res_valid_i,
  input  logic [SLOT_W-1:0] res_slot_i,
  input  logic [STAT_W-1:0] res_status_i,
  input  logic [CNT_W-1:0]  res_bytes_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [STAT_W-1:0] rd_status_o,
  output logic [CNT_W-1:0]  rd_bytes_o,
  output logic [NUM_UF-1:0] ss_active_o,
  output logic [NUM_UF-1:0] cs_active_o,
  output logic              load_err_o,
  output logic              done_o
);
  import iso_split_pkg::*;

  localparam logic [NUM_UF-1:0] IN_BAD_MASK = ~((NUM_UF'(1) << IN_SS_LIMIT) - NUM_UF'(1));

  // descriptor state
  logic [NUM_UF-1:0] ss_q, ss_d;
  logic [NUM_UF-1:0] cs_q, cs_d;
  logic [FRM_W-1:0]  frame_q, frame_d;
  logic              is_in_q, is_in_d;
  logic              err_q, err_d;
  logic              desc_en;

  // request state
  logic              rv_q, rv_d;
  logic              rcs_q, rcs_d;
  logic [SLOT_W-1:0] rslot_q, rslot_d;

  logic              frame_hit;
  logic              pick_hit;
  req_kind_e         pick_kind;
  logic              load_ok;
  logic              res_take;
  logic              slot_ss;
  logic              slot_cs;
  logic [STAT_W-1:0] stat_kept;

  iso_split_pick #(.NUM_UF(NUM_UF), .SLOT_W(SLOT_W)) u_pick (
    .ss_act_i    (ss_q),
    .cs_act_i    (cs_q),
    .frame_hit_i (frame_hit),
    .uframe_i    (cur_uframe_i),
    .hit_o       (pick_hit),
    .kind_o      (pick_kind)
  );

  iso_slot_store #(.NUM_UF(NUM_UF), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all_i  (load_i),
    .wr_en_i    (res_take),
    .wr_slot_i  (res_slot_i),
    .wr_stat_i  (stat_kept),
    .wr_bytes_i (res_bytes_i),
    .rd_slot_i  (rd_slot_i),
    .rd_stat_o  (rd_status_o),
    .rd_bytes_o (rd_bytes_o)
  );

  // descriptor next state
  always_comb begin
    frame_hit = (cur_frame_i == frame_q);
    load_ok   = ~(load_is_in_i & |(load_ss_mask_i & IN_BAD_MASK));
    slot_ss   = ss_q[res_slot_i];
    slot_cs   = cs_q[res_slot_i];
    res_take  = res_valid_i & ~load_i & (slot_ss | slot_cs);
    stat_kept = res_status_i & status_keep(is_in_q);

    ss_d    = ss_q;
    cs_d    = cs_q;
    frame_d = frame_q;
    is_in_d = is_in_q;
    err_d   = err_q;
    desc_en = 1'b0;

    if (load_i) begin
      desc_en = 1'b1;
      frame_d = load_frame_i;
      is_in_d = load_is_in_i;
      if (load_ok) begin
        ss_d  = load_ss_mask_i;
        cs_d  = load_is_in_i ? load_cs_mask_i : '0;
        err_d = 1'b0;
      end else begin
        ss_d  = '0;
        cs_d  = '0;
        err_d = 1'b1;
      end
    end else if (res_take) begin
      desc_en = 1'b1;
      if (slot_ss) begin
        ss_d[res_slot_i] = 1'b0;
      end else begin
        cs_d[res_slot_i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q    <= '0;
      cs_q    <= '0;
      frame_q <= '0;
      is_in_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (desc_en) begin
      ss_q    <= ss_d;
      cs_q    <= cs_d;
      frame_q <= frame_d;
      is_in_q <= is_in_d;
      err_q   <= err_d;
    end
  end

  // request next state
  always_comb begin
    rv_d    = tick_i & ~load_i & pick_hit;
    rcs_d   = (pick_kind == REQ_COMPLETE);
    rslot_d = cur_uframe_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      rcs_q   <= 1'b0;
      rslot_q <= '0;
    end else begin
      rv_q <= rv_d;
      if (rv_d) begin
        rcs_q   <= rcs_d;
        rslot_q <= rslot_d;
      end
    end
  end

  always_comb begin
    req_valid_o = rv_q;
    req_is_cs_o = rcs_q;
    req_slot_o  = rslot_q;
    ss_active_o = ss_q;
    cs_active_o = cs_q;
    load_err_o  = err_q;
    done_o      = ~|{ss_q, cs_q};
  end
endmodule

// File: rtl/iso_split_checker.sv
module iso_split_checker #(
  parameter int unsigned NUM_UF      = 8,
  parameter int unsigned FRM_W       = 5,
  parameter int unsigned IN_SS_LIMIT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              tick_i,
  input logic [FRM_W-1:0]  cur_frame_i,
  input logic [FRM_W-1:0]  frame_q,
  input logic              is_in_q,
  input logic [NUM_UF-1:0] ss_active_o,
  input logic [NUM_UF-1:0] cs_active_o,
  input logic              req_valid_o
);
  p_frame_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && cur_frame_i != frame_q) |=> !req_valid_o);

  p_in_low_slots_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_in_q |-> ((ss_active_o >> IN_SS_LIMIT) == '0));

  p_no_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (((ss_active_o & ~$past(ss_active_o)) == '0) &&
                 ((cs_active_o & ~$past(cs_active_o)) == '0)));

  p_out_no_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !is_in_q |-> (cs_active_o == '0));

  p_tick_needed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !req_valid_o);
endmodule

bind iso_split_sched iso_split_checker #(
  .NUM_UF(NUM_UF), .FRM_W(FRM_W), .IN_SS_LIMIT(IN_SS_LIMIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .tick_i      (tick_i),
  .cur_frame_i (cur_frame_i),
  .frame_q     (frame_q),
  .is_in_q     (is_in_q),
  .ss_active_o (ss_active_o),
  .cs_active_o (cs_active_o),
  .req_valid_o (req_valid_o)
);

// File: tb/iso_split_sched_test.sv
module iso_split_sched_test;
  localparam int NUF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] load_ss_mask_i = '0;
  logic [7:0] load_cs_mask_i = '0;
  logic       load_is_in_i = 1'b0;
  logic [4:0] load_frame_i = '0;
  logic       tick_i = 1'b0;
  logic [4:0] cur_frame_i = '0;
  logic [2:0] cur_uframe_i = '0;
  logic       req_valid_o, req_is_cs_o;
  logic [2:0] req_slot_o;
  logic       res_valid_i = 1'b0;
  logic [2:0] res_slot_i = '0;
  logic [2:0] res_status_i = '0;
  logic [7:0] res_bytes_i = '0;
  logic [2:0] rd_slot_i = '0;
  logic [2:0] rd_status_o;
  logic [7:0] rd_bytes_o;
  logic [7:0] ss_active_o, cs_active_o;
  logic       load_err_o, done_o;

  int n_chk = 0;
  int n_err = 0;

  // bench model
  logic [7:0] m_ss, m_cs;
  logic       m_in, m_err;
  logic [4:0] m_frame;
  logic [2:0] m_stat [NUF];
  logic [7:0] m_bytes [NUF];

  always #10 clk = ~clk;

  iso_split_sched uut (.*);

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic in_ok(input logic is_in, input logic [7:0] ss);
    return !(is_in && (ss[7:4] != 4'h0));
  endfunction

  function automatic logic [2:0] keep_stat(input logic is_in, input logic [2:0] st);
    return st & (is_in ? 3'b011 : 3'b101);
  endfunction

  task automatic check_state(input string req);
    chk({req, " ss"}, 32'(ss_active_o), 32'(m_ss));
    chk({req, " cs"}, 32'(cs_active_o), 32'(m_cs));
    chk({req, " err"}, 32'(load_err_o), 32'(m_err));
    chk({"R9 done ", req}, 32'(done_o), 32'((m_ss | m_cs) == 8'h00));
  endtask

  task automatic check_slots(input string req);
    for (int s = 0; s < NUF; s++) begin
      rd_slot_i = 3'(s);
      #1;
      chk({req, " R10 status"}, 32'(rd_status_o), 32'(m_stat[s]));
      chk({req, " R10 bytes"}, 32'(rd_bytes_o), 32'(m_bytes[s]));
    end
  endtask

  task automatic do_load(input logic is_in, input logic [7:0] ss, input logic [7:0] cs,
                         input logic [4:0] fr);
    @(negedge clk);
    load_i = 1'b1; load_is_in_i = is_in; load_ss_mask_i = ss;
    load_cs_mask_i = cs; load_frame_i = fr;
    @(negedge clk);
    load_i = 1'b0;
    m_in = is_in; m_frame = fr;
    if (in_ok(is_in, ss)) begin
      m_ss = ss; m_cs = is_in ? cs : 8'h00; m_err = 1'b0;
    end else begin
      m_ss = 8'h00; m_cs = 8'h00; m_err = 1'b1;
    end
    for (int s = 0; s < NUF; s++) begin
      m_stat[s] = '0; m_bytes[s] = '0;
    end
  endtask

  // tick: returns what the model expects and checks the request one cycle later
  task automatic do_tick(input logic [4:0] fr, input logic [2:0] uf, output logic issued);
    logic exp_v, exp_cs;
    exp_v  = (fr == m_frame) && (m_ss[uf] || m_cs[uf]);
    exp_cs = !m_ss[uf];
    @(negedge clk);
    tick_i = 1'b1; cur_frame_i = fr; cur_uframe_i = uf;
    @(negedge clk);
    tick_i = 1'b0;
    chk((fr == m_frame) ? "R6 req_valid" : "R3 req_valid (frame mismatch)",
        32'(req_valid_o), 32'(exp_v));
    if (exp_v) begin
      chk("R6 req_slot", 32'(req_slot_o), 32'(uf));
      chk("R6 req_is_cs", 32'(req_is_cs_o), 32'(exp_cs));
    end
    @(negedge clk);
    chk("R6 one-cycle request", 32'(req_valid_o), 32'(0));
    issued = exp_v;
  endtask

  task automatic do_result(input logic [2:0] s, input logic [2:0] st, input logic [7:0] by);
    @(negedge clk);
    res_valid_i = 1'b1; res_slot_i = s; res_status_i = st; res_bytes_i = by;
    @(negedge clk);
    res_valid_i = 1'b0;
    if (m_ss[s] || m_cs[s]) begin
      m_stat[s] = keep_stat(m_in, st);
      m_bytes[s] = by;
      if (m_ss[s]) m_ss[s] = 1'b0;
      else m_cs[s] = 1'b0;
    end
  endtask

  initial begin
    logic iss;
    void'($urandom(32'd7731));
    m_ss = '0; m_cs = '0; m_in = 1'b0; m_err = 1'b0; m_frame = '0;
    for (int s = 0; s < NUF; s++) begin m_stat[s] = '0; m_bytes[s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset");
    chk("R6 reset req_valid", 32'(req_valid_o), 32'(0));

    // directed: start mask 0x01, complete mask 0x04
    do_load(1'b1, 8'h01, 8'h04, 5'd9);
    check_state("R1 load");
    for (int u = 0; u < NUF; u++) begin
      do_tick(5'd9, 3'(u), iss);
      if (iss) do_result(3'(u), 3'b011, 8'(8'h10 + u));
    end
    check_state("R2 clear after schedule");
    check_slots("R8 schedule");

    // frame mismatch
    do_load(1'b1, 8'h0F, 8'hF0, 5'd3);
    for (int u = 0; u < NUF; u++) do_tick(5'd4, 3'(u), iss);
    check_state("R3 mismatch keeps masks");

    // IN rejection boundary
    do_load(1'b1, 8'h08, 8'h00, 5'd1);
    chk("R4 slot3 accepted err", 32'(load_err_o), 32'(0));
    do_load(1'b1, 8'h10, 8'h01, 5'd1);
    check_state("R4 slot4 rejected");
    do_load(1'b1, 8'h80, 8'h00, 5'd1);
    chk("R4 slot7 rejected err", 32'(load_err_o), 32'(1));

    // OUT: complete mask dropped, status placement
    do_load(1'b0, 8'hC1, 8'hFF, 5'd2);
    check_state("R5 out load");
    do_tick(5'd2, 3'd7, iss);
    do_result(3'd7, 3'b111, 8'h33);
    do_result(3'd5, 3'b111, 8'h44); // inactive slot
    check_slots("R7 out status");
    do_load(1'b1, 8'h02, 8'h02, 5'd2);
    do_result(3'd1, 3'b111, 8'h55);
    check_state("R2 ss first");
    do_result(3'd1, 3'b110, 8'h66);
    check_slots("R7 in status");
    check_state("R9 done");

    // load beats result
    do_load(1'b1, 8'h04, 8'h00, 5'd6);
    @(negedge clk);
    load_i = 1'b1; res_valid_i = 1'b1; res_slot_i = 3'd2; res_status_i = 3'b001;
    res_bytes_i = 8'h77;
    @(negedge clk);
    load_i = 1'b0; res_valid_i = 1'b0;
    check_state("R1 load wins");
    check_slots("R1 load wins");

    // random
    for (int it = 0; it < 60; it++) begin
      logic       di;
      logic [7:0] ss, cs;
      logic [4:0] fr;
      di = 1'($urandom);
      ss = 8'($urandom);
      if (di && ($urandom % 4 != 0)) ss[7:4] = 4'h0;
      cs = 8'($urandom);
      fr = 5'($urandom);
      do_load(di, ss, cs, fr);
      check_state("R4 R5 random load");
      for (int u = 0; u < NUF; u++) begin
        logic [4:0] tf;
        tf = ($urandom % 4 == 0) ? 5'(fr + 1) : fr;
        do_tick(tf, 3'(u), iss);
        if (iss) do_result(3'(u), 3'($urandom), 8'($urandom));
        if ($urandom % 5 == 0) do_result(3'($urandom), 3'($urandom), 8'($urandom));
      end
      check_state("R2 random");
      check_slots("R7 R8 random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule